// File: doc/BRIEF.md
# External Bus Chip-Select and Strobe Decoder

This block turns the demultiplexed 16-bit address and the three active-low bus strobes (read, write, code fetch) of a small 8-bit controller into the select lines for its memories and peripherals. The lower half of the address space goes to RAM. The upper half goes to flash, except for the top 2 KiB, which is a peripheral window. That window is divided into eight 256-byte slots, and each slot has its own active-low select.

The read and code-fetch strobes are merged into one memory output enable, so code and data share a single 64 KiB space. The highest slot also drives a character LCD. For that slot the block produces an active-high enable pulse. The LCD's register-select and direction lines come straight from two low address bits, so they are settled before the pulse starts. Every output is a pure combinational function of the inputs, so the block has no clock and no reset.

Top module: `xbus_decoder`

## Requirements
- R1: `ram_cs_n` is 0 exactly when addr[15] is 0, which is the range 0x0000–0x7FFF.
- R2: `flash_cs_n` is 0 exactly when addr[15] is 1 and at least one of addr[14:11] is 0, which is the range 0x8000–0xF7FF.
- R3: For 0xF800–0xFFFF, exactly one bit of `periph_cs_n` is 0: bit index addr[10:8], so each bit owns 256 bytes. Outside that range all eight bits are 1.
- R4: For every address, exactly one of three things holds: RAM selected, flash selected, or some peripheral bit selected.
- R5: `mem_oe_n` is 0 exactly when `rd_n` or `psen_n` is 0. `wr_n` has no effect on it.
- R6: `lcd_en` is 1 exactly when the address is in slot 7 (0xFF00–0xFFFF) and at least one of `rd_n`, `wr_n`, `psen_n` is 0.
- R7: When all three strobes are 1, `lcd_en` is 0 for every address.
- R8: `lcd_rs` equals addr[0] and `lcd_rw` equals addr[1], whatever the strobes are.
- R9: The chip selects depend only on the address. Changing only the strobes leaves `ram_cs_n`, `flash_cs_n` and `periph_cs_n` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr | input | 16 | Demultiplexed bus address |
| rd_n | input | 1 | Data read strobe, active low |
| wr_n | input | 1 | Data write strobe, active low |
| psen_n | input | 1 | Code fetch strobe, active low |
| ram_cs_n | output | 1 | RAM select, active low |
| flash_cs_n | output | 1 | Flash select, active low |
| periph_cs_n | output | 8 | Peripheral slot selects, active low |
| mem_oe_n | output | 1 | Merged memory output enable, active low |
| lcd_rs | output | 1 | LCD register/data select |
| lcd_rw | output | 1 | LCD read/write select |
| lcd_en | output | 1 | LCD enable, active high |

## Verification
The embedded checks hold on every input change:
- exactly one region is decoded, and at most one slot select is low;
- the LCD enable stays low when no strobe is active;
- the LCD enable rises only together with its own slot select;
- a lone write never opens the memory output enable.

Only the bench scenarios can show the following:
- the region boundaries fall at exactly 0x7FFF/0x8000 and 0xF7FF/0xF800;
- the slot index follows addr[10:8];
- the LCD control bits follow addr[1:0];
- the selects stay put while only the strobes change.

The bench covers these with a sweep of every address, random strobes and directed edge addresses.

// File: rtl/xbus_dec_pkg.sv
package xbus_dec_pkg;
  typedef struct packed {
    logic rd_n;
    logic wr_n;
    logic psen_n;
  } strobe_t;

  function automatic logic any_strobe(input strobe_t s);
    return ~(s.rd_n & s.wr_n & s.psen_n);
  endfunction
endpackage

// File: rtl/xbus_region.sv
module xbus_region #(
  parameter int ADDR_W   = 16,
  parameter int WIN_LOG2 = 11
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              ram_cs_n,
  output logic              flash_cs_n,
  output logic              win_hit
);
  localparam int HI = ADDR_W - 1;

  always_comb begin
    win_hit    = &addr[HI:WIN_LOG2];
    ram_cs_n   = addr[HI];
    flash_cs_n = ~(addr[HI] & ~win_hit);
  end

  always_comb begin
    p_one_region_r4: assert ($countones({~ram_cs_n, ~flash_cs_n, win_hit}) == 1)
      else $error("region decode not exclusive");
  end
endmodule

// File: rtl/xbus_slot.sv
module xbus_slot #(
  parameter int SLOTS     = 8,
  parameter int SLOT_BITS = $clog2(SLOTS)
) (
  input  logic                 win_hit,
  input  logic [SLOT_BITS-1:0] slot,
  output logic [SLOTS-1:0]     sel_n
);
  for (genvar g = 0; g < SLOTS; g++) begin : g_sel
    assign sel_n[g] = ~(win_hit && (slot == SLOT_BITS'(g)));
  end

  always_comb begin
    p_slot_onehot_r3: assert ($onehot0(~sel_n) && (win_hit == (sel_n != '1)))
      else $error("slot select not one-hot");
  end
endmodule

// File: rtl/xbus_lcd.sv
module xbus_lcd
  import xbus_dec_pkg::*;
(
  input  logic    slot_cs_n,
  input  strobe_t stb,
  input  logic    rs_bit,
  input  logic    rw_bit,
  output logic    lcd_rs,
  output logic    lcd_rw,
  output logic    lcd_en
);
  logic all_idle;

  always_comb begin
    all_idle = stb.rd_n & stb.wr_n & stb.psen_n;
    lcd_en   = ~(slot_cs_n | all_idle);
    lcd_rs   = rs_bit;
    lcd_rw   = rw_bit;
  end

  always_comb begin
    p_lcd_quiet_r7: assert (any_strobe(stb) || !lcd_en)
      else $error("lcd enable without strobe");
    p_lcd_slot_r6: assert (!lcd_en || !slot_cs_n)
      else $error("lcd enable outside its slot");
  end
endmodule

// File: rtl/xbus_decoder.sv
module xbus_decoder
  import xbus_dec_pkg::*;
#(
  parameter int ADDR_W         = 16,
  parameter int SLOTS          = 8,
  parameter int SLOT_SIZE_LOG2 = 8,
  parameter int LCD_SLOT       = 7,
  parameter int LCD_RS_BIT     = 0,
  parameter int LCD_RW_BIT     = 1
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              psen_n,
  output logic              ram_cs_n,
  output logic              flash_cs_n,
  output logic [SLOTS-1:0]  periph_cs_n,
  output logic              mem_oe_n,
  output logic              lcd_rs,
  output logic              lcd_rw,
  output logic              lcd_en
);
  localparam int SLOT_BITS = $clog2(SLOTS);
  localparam int WIN_LOG2  = SLOT_SIZE_LOG2 + SLOT_BITS;

  strobe_t stb;
  logic    win_hit;

  assign stb      = '{rd_n: rd_n, wr_n: wr_n, psen_n: psen_n};
  assign mem_oe_n = stb.rd_n & stb.psen_n;

  xbus_region #(.ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2)) u_region (
    .addr      (addr),
    .ram_cs_n  (ram_cs_n),
    .flash_cs_n(flash_cs_n),
    .win_hit   (win_hit)
  );

  xbus_slot #(.SLOTS(SLOTS), .SLOT_BITS(SLOT_BITS)) u_slot (
    .win_hit(win_hit),
    .slot   (addr[WIN_LOG2-1:SLOT_SIZE_LOG2]),
    .sel_n  (periph_cs_n)
  );

  xbus_lcd u_lcd (
    .slot_cs_n(periph_cs_n[LCD_SLOT]),
    .stb      (stb),
    .rs_bit   (addr[LCD_RS_BIT]),
    .rw_bit   (addr[LCD_RW_BIT]),
    .lcd_rs   (lcd_rs),
    .lcd_rw   (lcd_rw),
    .lcd_en   (lcd_en)
  );

  always_comb begin
    p_write_no_oe_r5: assert (!(rd_n && psen_n && !wr_n) || mem_oe_n)
      else $error("write opened memory output enable");
    p_lcd_region_r6: assert (!lcd_en || (ram_cs_n && flash_cs_n))
      else $error("lcd enable with memory selected");
  end
endmodule

// File: tb/xbus_decoder_tb.sv
module xbus_decoder_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] addr = '0;
  logic        rd_n = 1'b1, wr_n = 1'b1, psen_n = 1'b1;
  logic        ram_cs_n, flash_cs_n, mem_oe_n, lcd_rs, lcd_rw, lcd_en;
  logic [7:0]  periph_cs_n;
  int          n_chk = 0, n_bad = 0, cyc = 0;

  always #10 clk = ~clk;

  xbus_decoder u_dut (
    .addr(addr), .rd_n(rd_n), .wr_n(wr_n), .psen_n(psen_n),
    .ram_cs_n(ram_cs_n), .flash_cs_n(flash_cs_n), .periph_cs_n(periph_cs_n),
    .mem_oe_n(mem_oe_n), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_en(lcd_en)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%h act=%h exp=%h", req, addr, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_periph(input logic [15:0] a);
    logic [7:0] v = 8'hFF;
    if (a >= 16'hF800) v[a[10:8]] = 1'b0;
    return v;
  endfunction

  task automatic check_all();
    logic in_win, strobe;
    in_win = (addr >= 16'hF800);
    strobe = !rd_n || !wr_n || !psen_n;
    chk("R1 ram", 16'(ram_cs_n), 16'(addr >= 16'h8000));
    chk("R2 flash", 16'(flash_cs_n), 16'(!(addr >= 16'h8000 && !in_win)));
    chk("R3 periph", 16'(periph_cs_n), 16'(exp_periph(addr)));
    chk("R4 exclusive", 16'($countones({~ram_cs_n, ~flash_cs_n, ~periph_cs_n})), 16'd1);
    chk("R5 oe", 16'(mem_oe_n), 16'(rd_n && psen_n));
    chk("R6 lcd_en", 16'(lcd_en), 16'(addr >= 16'hFF00 && strobe));
    if (!strobe) chk("R7 lcd idle", 16'(lcd_en), 16'd0);
    chk("R8 rs/rw", 16'({lcd_rw, lcd_rs}), 16'(addr[1:0]));
  endtask

  task automatic apply(input logic [15:0] a, input logic [2:0] s);
    @(posedge clk);
    #2;
    addr = a; {rd_n, wr_n, psen_n} = s;
    @(negedge clk);
    check_all();
  endtask

  task automatic strobe_only(input logic [15:0] a);
    logic [9:0] ref_sel;
    apply(a, 3'b111);
    ref_sel = {ram_cs_n, flash_cs_n, periph_cs_n};
    for (int s = 0; s < 8; s++) begin
      apply(a, 3'(s));
      chk("R9 sel vs strobe", 16'({ram_cs_n, flash_cs_n, periph_cs_n}), 16'(ref_sel));
    end
  endtask

  initial begin
    logic [2:0] pat;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_all();
    // directed boundaries and LCD corners
    apply(16'h7FFF, 3'b011); apply(16'h8000, 3'b110);
    apply(16'hF7FF, 3'b011); apply(16'hF800, 3'b101);
    apply(16'hFEFF, 3'b011); apply(16'hFF00, 3'b111);
    apply(16'hFF01, 3'b101); apply(16'hFF02, 3'b011);
    apply(16'hFFFF, 3'b110); apply(16'hFFFF, 3'b111);
    apply(16'hFF03, 3'b101); apply(16'hFA00, 3'b101);
    strobe_only(16'h1234); strobe_only(16'hC000); strobe_only(16'hFF00);
    strobe_only(16'hF900);
    // full address sweep with random strobes
    for (int a = 0; a < 65536; a++) begin
      case ($urandom_range(0, 4))
        0: pat = 3'b111;
        1: pat = 3'b011;
        2: pat = 3'b101;
        3: pat = 3'b110;
        default: pat = 3'($urandom);
      endcase
      apply(16'(a), pat);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=%0d exp<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule